// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Alternate Function

This block models a group of port bits, each with an internal pull-up, a write-loaded output latch and a shared alternate function. The pull-down device of each bit turns on when either the output latch bit or the alternate-output bit is 0. When both are 1, the pull-up holds the pin high and an external device may pull it low. An alternate-output bit that no peripheral is using rests at 1, so the pin then follows the latch.

Each bit has three input paths. The first returns the level seen at the pin. The second returns the latch contents, chosen by a select input. The third feeds the pin level through a two-flop synchronizer to peripheral logic, and also gives a one-clock pulse on each falling edge, for use as an external interrupt request. A pin whose latch holds 0 is clamped low, so an external request on that pin cannot be seen.

The external pull-low on each pin is modelled as an input, and the resolved pin level is an output. Reset is asynchronous and active-low. Its release is synchronized inside the block.

Top module: `qb_port`

## Requirements
- R1: After reset the latch reads all ones, the pull-down outputs are all 0, the pin levels and synchronized alternate inputs are all 1, and no falling-edge pulse is present.
- R2: When `bus_we` is 1 at a clock edge, the latch loads `bus_wdata`. When `bus_we` is 0, the latch holds its value whatever `bus_wdata` carries.
- R3: For each bit, `pull_dn` is 1 exactly when the latch bit or the registered alternate-output bit is 0.
- R4: For each bit, `pin_level` is 0 when `pull_dn` is 1 or `ext_low` is 1, and is 1 otherwise.
- R5: With `rd_sel_latch` = 1, `rd_data` returns the latch contents. With `rd_sel_latch` = 0, it returns `pin_level`.
- R6: `alt_out` is registered and resets to all ones. A 0 on an `alt_out` bit turns on that bit's pull-down from the next clock edge.
- R7: `alt_in` equals `pin_level` as it was two clock edges earlier.
- R8: A falling `pin_level` bit gives a 1 on the matching `alt_fall` bit for exactly one clock. The pulse rises at the second clock edge after the fall.
- R9: When a latch bit holds 0, a low pulse applied through `ext_low` on that bit gives no `alt_fall` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | W | Internal bus data for the latch |
| bus_we | input | 1 | Write pulse that loads the latch |
| rd_sel_latch | input | 1 | Read source: 1 = latch, 0 = pin |
| rd_data | output | W | Read data onto the internal bus |
| alt_out | input | W | Alternate-output bits, 1 when idle |
| alt_in | output | W | Synchronized pin level for peripherals |
| alt_fall | output | W | One-clock falling-edge pulse per bit |
| ext_low | input | W | External device pulls the pin low |
| pull_dn | output | W | Pull-down device enable per bit |
| pin_level | output | W | Resolved pin level |

## Verification
The checker tests these on every cycle: loading and holding the latch, the pull-down forcing the pin low, the pull-down that an alternate-output 0 causes one cycle later, the two-cycle synchronizer delay, and the single-cycle width of edge pulses. The bench sweeps all 256 latch values against varied alternate-output and external-drive patterns, so the pull-down combination and both read sources are checked against values computed in the bench. Only the scenarios can show the reset state, the exact cycle at which an interrupt pulse appears, and that a request on a pin clamped by a 0 in its latch is lost.

// File: rtl/qb_pkg.sv
package qb_pkg;
  parameter int unsigned QB_DEF_W = 8;
  localparam int unsigned QB_SYNC_STAGES = 2;

  typedef enum logic {
    RD_PIN   = 1'b0,
    RD_LATCH = 1'b1
  } qb_rd_src_e;
endpackage

// File: rtl/qb_rst_sync.sv
module qb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_s = stg_q[1];
endmodule

// File: rtl/qb_latch.sv
module qb_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] alt_d,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] alt_q
);
  logic [W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (we) latch_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      alt_q   <= '1;
    end else begin
      latch_q <= latch_d;
      alt_q   <= alt_d;
    end
  end
endmodule

// File: rtl/qb_drive.sv
module qb_drive #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] alt_q,
  input  logic [W-1:0] ext_low,
  output logic [W-1:0] pull_dn,
  output logic [W-1:0] pin_level
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pull_dn[i]   = ~(latch_q[i] & alt_q[i]);
    assign pin_level[i] = ~(pull_dn[i] | ext_low[i]);
  end
endmodule

// File: rtl/qb_sync.sv
module qb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_level,
  output logic [W-1:0] alt_in,
  output logic [W-1:0] alt_fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [W-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = pin_level;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign alt_in   = s2_q;
  assign alt_fall = s3_q & ~s2_q;
endmodule

// File: rtl/qb_port.sv
module qb_port #(
  parameter int unsigned W = qb_pkg::QB_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_wdata,
  input  logic         bus_we,
  input  logic         rd_sel_latch,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] alt_in,
  output logic [W-1:0] alt_fall,
  input  logic [W-1:0] ext_low,
  output logic [W-1:0] pull_dn,
  output logic [W-1:0] pin_level
);
  import qb_pkg::*;

  logic         rst_n_s;
  logic [W-1:0] latch_q;
  logic [W-1:0] alt_q;
  qb_rd_src_e   rd_src;

  qb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  qb_latch #(.W(W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .alt_d   (alt_out),
    .latch_q (latch_q),
    .alt_q   (alt_q)
  );

  qb_drive #(.W(W)) u_drive (
    .latch_q   (latch_q),
    .alt_q     (alt_q),
    .ext_low   (ext_low),
    .pull_dn   (pull_dn),
    .pin_level (pin_level)
  );

  qb_sync #(.W(W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pin_level (pin_level),
    .alt_in    (alt_in),
    .alt_fall  (alt_fall)
  );

  assign rd_src = qb_rd_src_e'(rd_sel_latch);

  always_comb begin
    rd_data = pin_level;
    if (rd_src == RD_LATCH) rd_data = latch_q;
  end
endmodule

// File: rtl/qb_port_chk.sv
module qb_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n_s,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] alt_out,
  input logic [W-1:0] pull_dn,
  input logic [W-1:0] pin_level,
  input logic [W-1:0] alt_in,
  input logic [W-1:0] alt_fall
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)            cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_we |=> (latch_q == $past(bus_wdata)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_we |=> $stable(latch_q));

  p_pulldown_low_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pull_dn & pin_level) == '0);

  p_alt_drive_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cyc_q != 2'd0) |-> ((~$past(alt_out) & ~pull_dn) == '0));

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cyc_q == 2'd3) |-> (alt_in == $past(pin_level, 2)));

  p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alt_fall != '0) |=> ((alt_fall & $past(alt_fall)) == '0));
endmodule

bind qb_port qb_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .latch_q   (latch_q),
  .alt_out   (alt_out),
  .pull_dn   (pull_dn),
  .pin_level (pin_level),
  .alt_in    (alt_in),
  .alt_fall  (alt_fall)
);

// File: tb/qb_port_bench.sv
module qb_port_bench;
  localparam int unsigned W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] bus_wdata;
  logic         bus_we;
  logic         rd_sel_latch;
  logic [W-1:0] rd_data;
  logic [W-1:0] alt_out;
  logic [W-1:0] alt_in;
  logic [W-1:0] alt_fall;
  logic [W-1:0] ext_low;
  logic [W-1:0] pull_dn;
  logic [W-1:0] pin_level;

  int checks;
  int fails;
  bit done;

  qb_port #(.W(W)) u_qb_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .rd_sel_latch (rd_sel_latch),
    .rd_data      (rd_data),
    .alt_out      (alt_out),
    .alt_in       (alt_in),
    .alt_fall     (alt_fall),
    .ext_low      (ext_low),
    .pull_dn      (pull_dn),
    .pin_level    (pin_level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr_latch(input logic [W-1:0] v);
    bus_wdata = v;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; bus_wdata = '0; bus_we = 1'b0; rd_sel_latch = 1'b1;
    alt_out = '1; ext_low = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd_sel_latch = 1'b1; #1;
    chk("R1 latch", rd_data, 8'hFF);
    chk("R1 pull_dn", pull_dn, 8'h00);
    chk("R1 pin", pin_level, 8'hFF);
    chk("R1 alt_in", alt_in, 8'hFF);
    chk("R1 alt_fall", alt_fall, 8'h00);

    // Sweep: R2 R3 R4 R5 R6 over all latch values
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] lv, av, ev, pd, pl;
      lv = v[W-1:0];
      av = 8'(v * 37 + 5);
      ev = 8'(v * 11);
      alt_out = av;
      ext_low = ev;
      wr_latch(lv);
      pd = ~(lv & av);
      pl = ~(pd | ev);
      rd_sel_latch = 1'b1; #1;
      chk("R2 load", rd_data, lv);
      chk("R3 pull_dn", pull_dn, pd);
      chk("R4 pin", pin_level, pl);
      rd_sel_latch = 1'b0; #1;
      chk("R5 read pin", rd_data, pl);
    end

    // R2 hold with write disabled
    alt_out = '1; ext_low = '0;
    wr_latch(8'h5A);
    bus_wdata = 8'hC3;
    cyc(3);
    rd_sel_latch = 1'b1; #1;
    chk("R2 hold", rd_data, 8'h5A);

    // R5 latch vs pin differ when external low
    wr_latch(8'hFF);
    ext_low = 8'h0F; #1;
    rd_sel_latch = 1'b1; #1;
    chk("R5 read latch", rd_data, 8'hFF);
    rd_sel_latch = 1'b0; #1;
    chk("R5 read pin low", rd_data, 8'hF0);
    ext_low = '0;
    cyc(4);

    // R6 alternate output registered
    alt_out = 8'hFE; #1;
    chk("R6 before edge", pull_dn, 8'h00);
    @(negedge clk);
    chk("R6 after edge", pull_dn, 8'h01);
    chk("R6 pin", pin_level, 8'hFE);
    alt_out = '1;
    cyc(5);

    // R7 R8 falling edge timing on bit 2
    ext_low = 8'h04;
    @(negedge clk);
    chk("R7 one edge", alt_in, 8'hFF);
    chk("R8 no early pulse", alt_fall, 8'h00);
    @(negedge clk);
    chk("R7 two edges", alt_in, 8'hFB);
    chk("R8 pulse", alt_fall, 8'h04);
    @(negedge clk);
    chk("R8 pulse width", alt_fall, 8'h00);
    ext_low = '0;
    cyc(4);
    chk("R7 recovered", alt_in, 8'hFF);
    chk("R8 no rising pulse", alt_fall, 8'h00);

    // R9 masked request: bit0 latch 0, bit1 latch 1
    wr_latch(8'hFE);
    cyc(4);
    ext_low = 8'h03;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 1) chk("R9 unmasked bit pulses", alt_fall, 8'h02);
      else        chk("R9 masked bit silent", alt_fall & 8'h01, 8'h00);
    end
    ext_low = '0;
    cyc(3);
    chk("R9 masked bit low", alt_in & 8'h01, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule